// File: doc/BRIEF.md
# Qualified Comparator Trip Latch

This block is the fast hardware path of an arc-fault protection chain. An external comparator reports, as one asynchronous bit, that the band-limited envelope of the string current is above its threshold. The block brings that bit into the system clock domain and raises a suspected-arc flag at once. It then counts the comparator's rising edges inside a qualification window whose length is programmable. A trip latch engages only when enough edges arrive inside one window. A single isolated spike therefore never trips, and the response time stays bounded by the window length.

Once engaged, the latch drives a direct trip output that needs no decision from the processor. The processor sees the suspected flag, the trip state and the live edge count. It can force a trip at any time. It can clear the latch, but only while the comparator is quiet, and it can never suppress a trip.

Top module: `arc_trip_qualifier`

## Requirements
- R1: `suspect` equals the comparator input delayed by a two-flop synchroniser. A change on `comp_in` ahead of clock edge k shows on `suspect` after edge k+1.
- R2: Only rising edges of the synchronised comparator are counted. When the count of edges within one window reaches `min_pulses`, `trip` goes high at the following clock edge. A `min_pulses` of 0 acts as 1.
- R3: The first counted edge opens a window and sets an internal timer to 1. The timer then increments by one each cycle. An edge counts toward qualification only while the timer is below `win_len`. In the cycle where the timer equals `win_len`, the window closes and the count returns to 0. If an edge falls in that closing cycle, it opens a new window with a count of 1 instead.
- R4: Once set, `trip` stays high whatever the comparator does, until a valid clear.
- R5: `clear_req` returns `trip` to 0 at the next edge only if the synchronised comparator is low. While that comparator is high, the request is ignored.
- R6: `force_trip` sets `trip` at the next edge. When `force_trip` and `clear_req` are high in the same cycle, the force wins.
- R7: `pulse_count` reports the edges counted in the open window. It reads 0 when no window is open and 0 after a qualification, which also closes the window.
- R8: While `rst_n` is low, `suspect`, `trip` and `pulse_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| comp_in | input | 1 | Asynchronous comparator output, high when the envelope is above threshold |
| win_len | input | WIN_W | Qualification window length in cycles |
| min_pulses | input | CNT_W | Edges needed within one window to trip |
| force_trip | input | 1 | Processor override that sets the trip latch |
| clear_req | input | 1 | Processor request to clear the trip latch |
| suspect | output | 1 | Immediate suspected-arc flag (synchronised comparator) |
| trip | output | 1 | Latched direct trip output |
| pulse_count | output | CNT_W | Status: edges counted in the open window |

## Verification
On every cycle the assertions check four rules. A latched trip persists unless a clear is requested. A trip cannot be cleared while the comparator is active. A force always results in a trip. The window count grows by at most one per cycle, stays below the threshold and never outlives the window timer. The bench scenarios cover behaviour that depends on stimulus history: the two-cycle flag latency, rejection of one isolated pulse, expiry of a partly filled window, and the boundary where an edge lands exactly on the closing cycle instead of one cycle earlier. They also cover the single-edge threshold and the priority of force over clear.

// File: rtl/arc_trip_pkg.sv
package arc_trip_pkg;

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_state_t;

    typedef struct packed {
        logic        active;
        logic [15:0] timer;
        logic [15:0] count;
    } qual_state_t;

endpackage

// File: rtl/arc_sync_edge.sv
module arc_sync_edge
    import arc_trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sync;
    assign rise  = st_q.sync & ~st_q.prev;

    // R1: the level seen downstream is the input two edges earlier
    p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.meta |=> level);
endmodule

// File: rtl/arc_window_qual.sv
module arc_window_qual
    import arc_trip_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] min_pulses,
    output logic             qualify,
    output logic [CNT_W-1:0] count
);
    localparam int CW = CNT_W + 1;

    logic             active_d, active_q;
    logic [WIN_W-1:0] timer_d, timer_q;
    logic [CNT_W-1:0] count_d, count_q;
    logic [CW-1:0]    eff_min, cnt_inc;

    always_comb begin
        eff_min  = (min_pulses == '0) ? CW'(1) : CW'(min_pulses);
        cnt_inc  = CW'(count_q) + CW'(1);
        active_d = active_q;
        timer_d  = timer_q;
        count_d  = count_q;
        qualify  = 1'b0;
        if (!active_q) begin
            if (rise) begin
                if (eff_min <= CW'(1)) begin
                    qualify = 1'b1;
                end else begin
                    active_d = 1'b1;
                    timer_d  = WIN_W'(1);
                    count_d  = CNT_W'(1);
                end
            end
        end else if (rise && timer_q < win_len && cnt_inc >= eff_min) begin
            qualify  = 1'b1;
            active_d = 1'b0;
            timer_d  = '0;
            count_d  = '0;
        end else if (timer_q >= win_len) begin
            if (rise && eff_min > CW'(1)) begin
                timer_d = WIN_W'(1);
                count_d = CNT_W'(1);
            end else if (rise) begin
                qualify  = 1'b1;
                active_d = 1'b0;
                timer_d  = '0;
                count_d  = '0;
            end else begin
                active_d = 1'b0;
                timer_d  = '0;
                count_d  = '0;
            end
        end else begin
            timer_d = timer_q + WIN_W'(1);
            if (rise) count_d = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            timer_q  <= '0;
            count_q  <= '0;
        end else begin
            active_q <= active_d;
            timer_q  <= timer_d;
            count_q  <= count_d;
        end
    end

    assign count = count_q;

    // R2: the count rises by at most one edge per cycle
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> CW'(count_q) <= CW'($past(count_q)) + CW'(1));
    // R2: an open window never holds a qualifying count
    p_count_below_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> CW'(count_q) < eff_min);
    // R3: no window outlives its programmed length
    p_window_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> timer_q <= win_len || $changed(win_len));
    // R7: a closed window reports an empty count
    p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> count_q == '0);
endmodule

// File: rtl/arc_trip_latch.sv
module arc_trip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic qualify,
    input  logic force_trip,
    input  logic clear_req,
    input  logic comp_level,
    output logic trip
);
    logic trip_d, trip_q;

    always_comb begin
        trip_d = trip_q;
        if (clear_req && !comp_level) trip_d = 1'b0;
        if (qualify || force_trip)    trip_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_d;
    end

    assign trip = trip_q;

    // R4: a latched trip holds unless a clear is requested
    p_trip_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q && !clear_req |=> trip_q);
    // R5: no clear while the comparator is active
    p_no_clear_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q && comp_level |=> trip_q);
    // R6: an override always trips
    p_force_trips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_trip |=> trip_q);
    // R2: a qualification always trips
    p_qualify_trips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> trip_q);
endmodule

// File: rtl/arc_trip_qualifier.sv
module arc_trip_qualifier #(
    parameter int WIN_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             comp_in,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] min_pulses,
    input  logic             force_trip,
    input  logic             clear_req,
    output logic             suspect,
    output logic             trip,
    output logic [CNT_W-1:0] pulse_count
);
    logic comp_level, comp_rise, qualify;

    arc_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (comp_in),
        .level    (comp_level),
        .rise     (comp_rise)
    );

    arc_window_qual #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (comp_rise),
        .win_len    (win_len),
        .min_pulses (min_pulses),
        .qualify    (qualify),
        .count      (pulse_count)
    );

    arc_trip_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .qualify    (qualify),
        .force_trip (force_trip),
        .clear_req  (clear_req),
        .comp_level (comp_level),
        .trip       (trip)
    );

    assign suspect = comp_level;

    // R8: reset leaves every output quiet
    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> !trip && !suspect && pulse_count == '0);
endmodule

// File: tb/arc_trip_qualifier_tb.sv
module arc_trip_qualifier_tb;
    localparam int WIN_W = 8;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             comp_in = 1'b0;
    logic [WIN_W-1:0] win_len = 8'd20;
    logic [CNT_W-1:0] min_pulses = 4'd3;
    logic             force_trip = 1'b0;
    logic             clear_req = 1'b0;
    logic             suspect, trip;
    logic [CNT_W-1:0] pulse_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        bit    exp_trip;
        bit    exp_susp;
        int    exp_cnt;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    arc_trip_qualifier #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .win_len(win_len),
        .min_pulses(min_pulses), .force_trip(force_trip), .clear_req(clear_req),
        .suspect(suspect), .trip(trip), .pulse_count(pulse_count)
    );

    task automatic expect_now(string tag, bit t, bit s, int c);
        exp_t e;
        e.tag = tag; e.exp_trip = t; e.exp_susp = s; e.exp_cnt = c;
        sb.push_back(e);
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one comparator pulse: two cycles high, two low, rises four cycles apart
    task automatic pulse();
        comp_in = 1'b1;
        cycles(2);
        comp_in = 1'b0;
        cycles(2);
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (trip !== e.exp_trip || suspect !== e.exp_susp ||
                    int'(pulse_count) != e.exp_cnt) begin
                    errors++;
                    $display("FAIL %s: trip=%0b suspect=%0b count=%0d expected trip=%0b suspect=%0b count=%0d",
                             e.tag, trip, suspect, pulse_count, e.exp_trip, e.exp_susp, e.exp_cnt);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(2);
        expect_now("R8 outputs during reset", 0, 0, 0);
        cycles(1);
        rst_n = 1'b1;
        cycles(1);
        expect_now("R8 outputs after reset", 0, 0, 0);

        // R1: flag appears after the second edge, not the first
        comp_in = 1'b1;
        cycles(1);
        expect_now("R1 suspect not yet after one edge", 0, 0, 0);
        cycles(1);
        expect_now("R1 suspect after two edges", 0, 1, 0);
        comp_in = 1'b0;
        cycles(2);
        // R2: an isolated spike opens a window but does not trip
        expect_now("R2 isolated spike counted, no trip", 0, 0, 1);
        cycles(25);
        expect_now("R3 window expiry clears count", 0, 0, 0);

        // R2 / R7: three edges inside a 20-cycle window
        pulse();
        pulse();
        expect_now("R7 count after two edges", 0, 0, 2);
        pulse();
        expect_now("R2 trip after third edge", 1, 0, 0);

        // R4: trip holds with the comparator quiet
        cycles(40);
        expect_now("R4 trip held while comparator quiet", 1, 0, 0);

        // R5: clear ignored while the comparator is active
        comp_in = 1'b1;
        cycles(3);
        clear_req = 1'b1;
        cycles(1);
        clear_req = 1'b0;
        expect_now("R5 clear ignored while active", 1, 1, 1);
        comp_in = 1'b0;
        cycles(30);
        clear_req = 1'b1;
        cycles(1);
        clear_req = 1'b0;
        expect_now("R5 clear accepted while quiet", 0, 0, 0);

        // R6: override trips, and beats a simultaneous clear
        force_trip = 1'b1;
        cycles(1);
        force_trip = 1'b0;
        expect_now("R6 override sets trip", 1, 0, 0);
        force_trip = 1'b1;
        clear_req = 1'b1;
        cycles(1);
        force_trip = 1'b0;
        clear_req = 1'b0;
        expect_now("R6 override wins over clear", 1, 0, 0);
        clear_req = 1'b1;
        cycles(1);
        clear_req = 1'b0;
        expect_now("R5 clear after override", 0, 0, 0);

        // R3 boundary: second edge lands on the closing cycle of a 4-cycle window
        win_len = 8'd4;
        min_pulses = 4'd2;
        pulse();
        pulse();
        expect_now("R3 edge on closing cycle starts new window", 0, 0, 1);
        cycles(10);
        expect_now("R3 reopened window expires", 0, 0, 0);

        // R3 boundary: same spacing with a 5-cycle window qualifies
        win_len = 8'd5;
        pulse();
        pulse();
        expect_now("R3 edge one cycle inside window trips", 1, 0, 0);
        clear_req = 1'b1;
        cycles(1);
        clear_req = 1'b0;
        expect_now("R5 clear before threshold tests", 0, 0, 0);

        // R2: threshold zero behaves as one, a single edge trips
        min_pulses = 4'd0;
        pulse();
        expect_now("R2 zero threshold trips on one edge", 1, 0, 0);
        clear_req = 1'b1;
        cycles(1);
        clear_req = 1'b0;
        min_pulses = 4'd1;
        pulse();
        expect_now("R2 threshold one trips on one edge", 1, 0, 0);

        cycles(2);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule